// File: doc/BRIEF.md
# Paged Digital I/O Interrupt Controller

This block is a register file for 48 general-purpose digital lines, reached over a byte-wide bus with a 16-byte address window. The 48 lines form six 8-bit ports. Each port has an output latch that drives its pins and a read path that returns the synchronized pin levels. The lower 24 lines, ports 0 to 2, also carry edge-detect interrupt logic. Each of these lines can be set to watch for a rising or a falling edge. When an enabled line sees its edge, it sets a sticky flag. The flags are summarized per port, and the summary drives one interrupt output.

Three addresses near the top of the window are shared between three register banks: edge polarity, edge enable and interrupt flags. A page register chooses which bank they reach. The same register holds one write-lock bit per port, so that software can freeze an output latch. The bus is a plain write strobe with a combinational read: `bus_rdata_o` always reflects `bus_addr_i`. The block does not handle pin electrical drive or bus bridging.

Top module: `pdio_irq_ctrl`

## Requirements
- R1: After reset every output latch, polarity, enable and flag bit is 0, page 0 is selected and no port is locked, so `pin_o` is 0, `irq_o` is 0 and every address reads 0 while the pins are low.
- R2: A write to address p (0 to 5) of an unlocked port loads `pin_o[8p+7:8p]` at that clock edge. A read of address p returns pins `8p+7:8p` through a two-flop synchronizer, so a pin change made before edge k is visible after edge k+1.
- R3: A write to address 7 sets the page from data bits 7:6 and the lock mask from bits 5:0. While lock bit p is 1, writes to port p leave its latch unchanged. Other ports are not affected.
- R4: Address 7 and addresses 0xB to 0xF read as 0. Writes to address 6 and to 0xB–0xF change nothing.
- R5: On page 1, a write to address 8+i (i = 0..2) sets the edge polarity of port i: 1 selects a rising edge and 0 selects a falling edge. On that page these addresses read as 0.
- R6: On page 2, a write to address 8+i sets the edge enables of port i, and these addresses read as 0. A flag bit is never set for a line whose enable bit is 0.
- R7: On page 3, a read of address 8+i returns the flag byte of port i. A qualifying pin edge applied before clock edge k sets its flag at edge k+2.
- R8: On page 3, a write to address 8+i clears every flag bit of port i written as 0 and keeps every bit written as 1. A new edge detected in the same cycle as a clear leaves the flag set.
- R9: Address 6 reads as pending bits: bit i is the OR of the flag byte of port i, and bits 7:3 are 0.
- R10: `irq_o` is 1 exactly when any flag bit is set.
- R11: On page 0, addresses 8 to 0xA read as 0 and writes to them change no polarity, enable or flag.
- R12: Edges on lines 24 to 47 (ports 3 to 5) never set a flag or raise `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe, one byte per cycle |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Combinational read data for `bus_addr_i` |
| pin_i | input | 48 | Line input levels, asynchronous |
| pin_o | output | 48 | Output latch values, 8 per port |
| irq_o | output | 1 | Interrupt request, OR of all flags |

## Verification
The assertions assume that the bus inputs are stable and defined at each rising clock edge, and that reset is asserted from time zero. They place no limit on `pin_i`: the synchronizer absorbs asynchronous changes, and every flag property is written in terms of registered state only. The stimulus drives every input on the falling edge, including pins, page and lock selections, and clear writes, so each value is settled a half period before the edge that samples it. Random address, data and pin patterns then cover any page or lock combination without breaking these assumptions.

// File: rtl/pdio_pkg.sv
`timescale 1ns/1ps
package pdio_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [1:0] {
    PG_NONE = 2'd0,
    PG_POL  = 2'd1,
    PG_EN   = 2'd2,
    PG_ID   = 2'd3
  } page_e;

  localparam logic [ADDR_W-1:0] ADR_PEND  = 4'h6;
  localparam logic [ADDR_W-1:0] ADR_PGLK  = 4'h7;
  localparam logic [ADDR_W-1:0] ADR_PAGED = 4'h8;
endpackage

// File: rtl/pdio_sync.sv
`timescale 1ns/1ps
module pdio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= {st_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/pdio_regs.sv
`timescale 1ns/1ps
module pdio_regs
  import pdio_pkg::*;
#(
  parameter int PORT_W  = 8,
  parameter int N_PORTS = 6,
  parameter int N_IRQ   = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [PORT_W-1:0]           wdata_i,
  output page_e                       page_o,
  output logic [N_PORTS-1:0]          lock_o,
  output logic [N_PORTS*PORT_W-1:0]   out_o,
  output logic [N_IRQ*PORT_W-1:0]     pol_o,
  output logic [N_IRQ*PORT_W-1:0]     en_o,
  output logic [N_IRQ-1:0]            id_wr_o
);
  localparam int PG_MSB = PORT_W - 1;

  page_e              page_q;
  logic [N_PORTS-1:0] lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= PG_NONE;
      lock_q <= '0;
    end else if (we_i && addr_i == ADR_PGLK) begin
      page_q <= page_e'(wdata_i[PG_MSB -: 2]);
      lock_q <= wdata_i[N_PORTS-1:0];
    end
  end

  generate
    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
      localparam logic [ADDR_W-1:0] PA = ADDR_W'(p);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                              out_o[p*PORT_W +: PORT_W] <= '0;
        else if (we_i && addr_i == PA && !lock_q[p]) out_o[p*PORT_W +: PORT_W] <= wdata_i;
      end
    end

    for (genvar i = 0; i < N_IRQ; i++) begin : g_paged
      localparam logic [ADDR_W-1:0] IA = ADR_PAGED + ADDR_W'(i);
      logic hit;
      assign hit = we_i && addr_i == IA;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          pol_o[i*PORT_W +: PORT_W] <= '0;
          en_o[i*PORT_W +: PORT_W]  <= '0;
        end else if (hit) begin
          if (page_q == PG_POL) pol_o[i*PORT_W +: PORT_W] <= wdata_i;
          if (page_q == PG_EN)  en_o[i*PORT_W +: PORT_W]  <= wdata_i;
        end
      end

      assign id_wr_o[i] = hit && page_q == PG_ID;
    end
  endgenerate

  assign page_o = page_q;
  assign lock_o = lock_q;
endmodule

// File: rtl/pdio_edge.sv
`timescale 1ns/1ps
module pdio_edge #(
  parameter int PORT_W = 8,
  parameter int N_IRQ  = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_IRQ*PORT_W-1:0]   lvl_i,
  input  logic [N_IRQ*PORT_W-1:0]   pol_i,
  input  logic [N_IRQ*PORT_W-1:0]   en_i,
  input  logic [N_IRQ-1:0]          id_wr_i,
  input  logic [PORT_W-1:0]         wdata_i,
  output logic [N_IRQ*PORT_W-1:0]   flag_o,
  output logic [N_IRQ-1:0]          pend_o
);
  localparam int LINES = N_IRQ * PORT_W;

  logic [LINES-1:0] prv_q;
  logic [LINES-1:0] rise, fall, evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prv_q <= '0;
    else         prv_q <= lvl_i;
  end

  assign rise = lvl_i & ~prv_q;
  assign fall = ~lvl_i & prv_q;
  assign evt  = en_i & ((pol_i & rise) | (~pol_i & fall));

  generate
    for (genvar i = 0; i < N_IRQ; i++) begin : g_flag
      logic [PORT_W-1:0] keep;
      // bits written 0 clear, a same-cycle event wins
      assign keep = id_wr_i[i] ? wdata_i : '1;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flag_o[i*PORT_W +: PORT_W] <= '0;
        else flag_o[i*PORT_W +: PORT_W] <=
               (flag_o[i*PORT_W +: PORT_W] & keep) | evt[i*PORT_W +: PORT_W];
      end

      assign pend_o[i] = |flag_o[i*PORT_W +: PORT_W];
    end
  endgenerate
endmodule

// File: rtl/pdio_irq_ctrl.sv
`timescale 1ns/1ps
module pdio_irq_ctrl
  import pdio_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int N_PORTS     = 6,
  parameter int N_IRQ       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        bus_we_i,
  input  logic [3:0]                  bus_addr_i,
  input  logic [PORT_W-1:0]           bus_wdata_i,
  output logic [PORT_W-1:0]           bus_rdata_o,
  input  logic [N_PORTS*PORT_W-1:0]   pin_i,
  output logic [N_PORTS*PORT_W-1:0]   pin_o,
  output logic                        irq_o
);
  localparam int LINES     = N_PORTS * PORT_W;
  localparam int IRQ_LINES = N_IRQ * PORT_W;

  page_e                 page_q;
  logic [N_PORTS-1:0]    lock_q;
  logic [IRQ_LINES-1:0]  pol_q, en_q, flag_q;
  logic [N_IRQ-1:0]      id_wr, pend;
  logic [LINES-1:0]      sync_q;

  pdio_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync_q)
  );

  pdio_regs #(.PORT_W(PORT_W), .N_PORTS(N_PORTS), .N_IRQ(N_IRQ)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (bus_we_i),
    .addr_i (bus_addr_i),
    .wdata_i(bus_wdata_i),
    .page_o (page_q),
    .lock_o (lock_q),
    .out_o  (pin_o),
    .pol_o  (pol_q),
    .en_o   (en_q),
    .id_wr_o(id_wr)
  );

  pdio_edge #(.PORT_W(PORT_W), .N_IRQ(N_IRQ)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (sync_q[IRQ_LINES-1:0]),
    .pol_i  (pol_q),
    .en_i   (en_q),
    .id_wr_i(id_wr),
    .wdata_i(bus_wdata_i),
    .flag_o (flag_q),
    .pend_o (pend)
  );

  always_comb begin
    bus_rdata_o = '0;
    for (int p = 0; p < N_PORTS; p++)
      if (bus_addr_i == ADDR_W'(p)) bus_rdata_o = sync_q[p*PORT_W +: PORT_W];
    if (bus_addr_i == ADR_PEND) bus_rdata_o = PORT_W'(pend);
    if (page_q == PG_ID)
      for (int i = 0; i < N_IRQ; i++)
        if (bus_addr_i == ADR_PAGED + ADDR_W'(i)) bus_rdata_o = flag_q[i*PORT_W +: PORT_W];
  end

  assign irq_o = |pend;
endmodule

// File: rtl/pdio_irq_ctrl_chk.sv
`timescale 1ns/1ps
module pdio_irq_ctrl_chk
  import pdio_pkg::*;
#(
  parameter int PORT_W  = 8,
  parameter int N_PORTS = 6,
  parameter int N_IRQ   = 3
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      bus_we_i,
  input logic [3:0]                bus_addr_i,
  input logic [PORT_W-1:0]         bus_rdata_o,
  input logic [N_PORTS*PORT_W-1:0] pin_o,
  input logic                      irq_o,
  input page_e                     page_q,
  input logic [N_PORTS-1:0]        lock_q,
  input logic [N_IRQ*PORT_W-1:0]   en_q,
  input logic [N_IRQ*PORT_W-1:0]   flag_q
);
  logic [N_PORTS*PORT_W-1:0] lock_lines;
  logic                      paged_addr;

  always_comb
    for (int p = 0; p < N_PORTS; p++) lock_lines[p*PORT_W +: PORT_W] = {PORT_W{lock_q[p]}};

  assign paged_addr = bus_addr_i >= ADR_PAGED && bus_addr_i < ADR_PAGED + ADDR_W'(N_IRQ);

  a_r3_locked_port_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_o ^ $past(pin_o)) & $past(lock_lines)) == '0);

  a_r4_pglk_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_addr_i == ADR_PGLK |-> bus_rdata_o == '0);

  a_r6_no_flag_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q & ~$past(flag_q) & ~$past(en_q)) == '0);

  a_r8_flag_falls_on_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~flag_q & $past(flag_q)) != '0) |->
      ($past(bus_we_i) && $past(page_q) == PG_ID && $past(paged_addr)));

  a_r9_pend_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_addr_i == ADR_PEND |-> bus_rdata_o[PORT_W-1:N_IRQ] == '0);

  a_r10_irq_tracks_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (flag_q != '0));

  a_r11_page0_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (page_q == PG_NONE && paged_addr) |-> bus_rdata_o == '0);
endmodule

bind pdio_irq_ctrl pdio_irq_ctrl_chk #(
  .PORT_W(PORT_W), .N_PORTS(N_PORTS), .N_IRQ(N_IRQ)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_rdata_o(bus_rdata_o),
  .pin_o      (pin_o),
  .irq_o      (irq_o),
  .page_q     (page_q),
  .lock_q     (lock_q),
  .en_q       (en_q),
  .flag_q     (flag_q)
);

// File: tb/pdio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module pdio_irq_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [3:0]  bus_addr_i = '0;
  logic [7:0]  bus_wdata_i = '0;
  logic [7:0]  bus_rdata_o;
  logic [47:0] pin_i = '0;
  logic [47:0] pin_o;
  logic        irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  pdio_irq_ctrl u_pdio_irq_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .pin_i(pin_i),
    .pin_o(pin_o), .irq_o(irq_o)
  );

  // reference state
  logic [47:0] m_s1, m_s2, m_out;
  logic [23:0] m_prv, m_pol, m_en, m_flag;
  logic [1:0]  m_page;
  logic [5:0]  m_lock;
  logic [47:0] pins;

  task automatic model_reset();
    m_s1 = '0; m_s2 = '0; m_out = '0; m_prv = '0; m_pol = '0; m_en = '0;
    m_flag = '0; m_page = '0; m_lock = '0;
  endtask

  function automatic logic [2:0] m_pend();
    return {|m_flag[23:16], |m_flag[15:8], |m_flag[7:0]};
  endfunction

  function automatic logic [7:0] m_read(input logic [3:0] a);
    if (a < 4'd6) return m_s2[a*8 +: 8];
    if (a == 4'd6) return {5'b0, m_pend()};
    if (a >= 4'd8 && a <= 4'hA && m_page == 2'd3) return m_flag[(a-8)*8 +: 8];
    return 8'h00;
  endfunction

  function automatic string rtag(input logic [3:0] a);
    if (a < 4'd6) return "R2";
    if (a == 4'd6) return "R9";
    if (a >= 4'd8 && a <= 4'hA)
      case (m_page)
        2'd0: return "R11";
        2'd1: return "R5";
        2'd2: return "R6";
        default: return "R7";
      endcase
    return "R4";
  endfunction

  task automatic model_step();
    logic [23:0] lvl, ev, keep;
    lvl  = m_s2[23:0];
    ev   = m_en & ((m_pol & lvl & ~m_prv) | (~m_pol & ~lvl & m_prv));
    keep = '1;
    if (bus_we_i && m_page == 2'd3 && bus_addr_i >= 4'd8 && bus_addr_i <= 4'hA)
      keep[(bus_addr_i-8)*8 +: 8] = bus_wdata_i;
    m_flag = (m_flag & keep) | ev;
    m_prv  = lvl;
    if (bus_we_i) begin
      if (bus_addr_i < 4'd6 && !m_lock[bus_addr_i]) m_out[bus_addr_i*8 +: 8] = bus_wdata_i;
      if (bus_addr_i >= 4'd8 && bus_addr_i <= 4'hA) begin
        if (m_page == 2'd1) m_pol[(bus_addr_i-8)*8 +: 8] = bus_wdata_i;
        if (m_page == 2'd2) m_en[(bus_addr_i-8)*8 +: 8]  = bus_wdata_i;
      end
      if (bus_addr_i == 4'd7) begin
        m_page = bus_wdata_i[7:6];
        m_lock = bus_wdata_i[5:0];
      end
    end
    m_s2 = m_s1;
    m_s1 = pin_i;
  endtask

  task automatic check(input logic [47:0] act, input logic [47:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [3:0] a, input logic [7:0] d);
    bus_we_i = we; bus_addr_i = a; bus_wdata_i = d; pin_i = pins;
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    bus_we_i = 1'b0;
    check(pin_o, m_out, "R2/R3 pin_o");
    check({47'b0, irq_o}, {47'b0, |m_flag}, "R10 irq_o");
  endtask

  task automatic rd(input logic [3:0] a, input string tag, input logic [7:0] exp);
    bus_we_i = 1'b0; bus_addr_i = a;
    #1;
    check({40'b0, bus_rdata_o}, {40'b0, exp}, tag);
    check({40'b0, bus_rdata_o}, {40'b0, m_read(a)}, {tag, " model"});
  endtask

  task automatic rdm(input logic [3:0] a);
    bus_we_i = 1'b0; bus_addr_i = a;
    #1;
    check({40'b0, bus_rdata_o}, {40'b0, m_read(a)}, rtag(a));
  endtask

  initial begin
    void'($urandom(32'hC0DE_5EED));
    pins = '0;
    model_reset();
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(pin_o, '0, "R1 pin_o");
    check({47'b0, irq_o}, '0, "R1 irq_o");
    rst_ni = 1'b1;
    for (int a = 0; a < 16; a++) rd(4'(a), "R1 read", 8'h00);

    // R2 write and synchronized read
    cyc(1, 4'd0, 8'hA5);
    check({40'b0, pin_o[7:0]}, {40'b0, 8'hA5}, "R2 port0 latch");
    pins[15:8] = 8'h3C;
    cyc(0, 4'd0, 8'h00);
    rd(4'd1, "R2 sync not yet", 8'h00);
    cyc(0, 4'd0, 8'h00);
    rd(4'd1, "R2 sync visible", 8'h3C);

    // R3 lock
    cyc(1, 4'd7, 8'h04);
    cyc(1, 4'd2, 8'hFF);
    check({40'b0, pin_o[23:16]}, '0, "R3 locked port2");
    cyc(1, 4'd1, 8'h11);
    check({40'b0, pin_o[15:8]}, {40'b0, 8'h11}, "R3 unlocked port1");
    rd(4'd7, "R4 pglk read", 8'h00);
    cyc(1, 4'hC, 8'hFF);
    rd(4'hC, "R4 high addr", 8'h00);

    // R11 page 0
    cyc(1, 4'd7, 8'h00);
    cyc(1, 4'd8, 8'hFF);
    rd(4'd8, "R11 page0 read", 8'h00);

    // R5 polarity, R6 enable
    cyc(1, 4'd7, 8'h40);
    cyc(1, 4'd8, 8'hFF);
    cyc(1, 4'd9, 8'h00);
    rd(4'd8, "R5 write-only", 8'h00);
    cyc(1, 4'd7, 8'h80);
    cyc(1, 4'd8, 8'h0F);
    cyc(1, 4'd9, 8'hFF);
    rd(4'd9, "R6 write-only", 8'h00);
    cyc(1, 4'd7, 8'hC0);
    rd(4'd8, "R7 no flag", 8'h00);

    // R7 rising on bit0, bit4 disabled
    pins[7:0] = 8'h11;
    cyc(0, 4'd0, 8'h00);
    cyc(0, 4'd0, 8'h00);
    rd(4'd8, "R7 flag not before edge k+2", 8'h00);
    cyc(0, 4'd0, 8'h00);
    rd(4'd8, "R7 R6 rising flag bit0 only", 8'h01);
    check({47'b0, irq_o}, 48'd1, "R10 irq high");
    rd(4'd6, "R9 pend port0", 8'h01);

    // falling edge on port1 bit3
    pins[15:8] = 8'h34;
    repeat (3) cyc(0, 4'd0, 8'h00);
    rd(4'd9, "R5 falling flag", 8'h08);
    rd(4'd6, "R9 pend two ports", 8'h03);
    cyc(1, 4'd6, 8'hFF);
    rd(4'd6, "R4 pend write ignored", 8'h03);

    // R8 clear semantics
    cyc(1, 4'd8, 8'h00);
    rd(4'd8, "R8 clear by 0", 8'h00);
    cyc(1, 4'd9, 8'hFF);
    rd(4'd9, "R8 keep by 1", 8'h08);
    pins[7:0] = 8'h12;
    cyc(0, 4'd0, 8'h00);
    cyc(0, 4'd0, 8'h00);
    cyc(1, 4'd8, 8'h00);
    rd(4'd8, "R8 edge wins over clear", 8'h02);

    // R12 upper ports never interrupt
    cyc(1, 4'd8, 8'h00);
    cyc(1, 4'd9, 8'h00);
    for (int k = 0; k < 6; k++) begin
      pins[47:24] = ~pins[47:24];
      cyc(0, 4'd0, 8'h00);
    end
    check({47'b0, irq_o}, '0, "R12 irq stays low");
    rd(4'd6, "R12 pend zero", 8'h00);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] a;
      if ($urandom_range(3) == 0) pins = pins ^ ({$urandom, $urandom} & {$urandom, $urandom});
      a = 4'($urandom_range(15));
      if ($urandom_range(5) == 0) a = 4'd7;
      cyc(1'($urandom_range(1)), a, 8'($urandom));
      rdm(4'($urandom_range(15)));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule